// File: doc/BRIEF.md
# Prime-Bank Address Mapper

This block splits a linear word address into a bank index and a word offset inside that bank. It serves an interleaved memory whose bank count is a prime of the form 2^m - 1 and whose banks each hold a power-of-two number of words. A prime bank count spreads strided accesses over all banks, so strides that are powers of two do not pile onto one bank.

The bank index is the address modulo the bank count. It is found without a divider. Bit k of the address is worth 2^(k mod m) modulo the bank count, and that weight is fixed when the block is built. The weights of the set bits are added. The sum is then folded back into m bits with end-around carries, and a folded result equal to the bank count is mapped to zero.

The word offset is the address modulo the words per bank, which is just the low address bits. The two moduli share no factor, so every address below (bank count x words per bank) lands on its own (bank, offset) pair. An optional output register stage is set by a parameter.

Top module: `prime_bank_mapper`

## Requirements
- R1: With `outValid` high, `bankIdx` equals the accepted address modulo Nb, where Nb = 2^BANK_BITS - 1 (7 by default).
- R2: With `outValid` high, `wordIdx` equals the accepted address modulo 2^WORD_BITS, which is its low WORD_BITS bits (64 words by default).
- R3: `bankIdx` never reaches Nb. Any address that is a multiple of Nb, including 0 and 7, gives bank 0.
- R4: With PIPE_STAGES = 1, `outValid` is `inValid` delayed by one clock. With PIPE_STAGES = 0, the path is combinational.
- R5: A cycle with `inValid` low leaves `bankIdx` and `wordIdx` holding their previous values and drives `outValid` low.
- R6: Over the addresses 0 to Nb*2^WORD_BITS - 1, no two addresses share a (bank, offset) pair, and every pair is used.
- R7: During and right after an active-low reset, `outValid`, `bankIdx` and `wordIdx` are all zero.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous reset, active low |
| inValid | input | 1 | Address on `addr` is to be mapped |
| addr | input | ADDR_W | Linear word address |
| outValid | output | 1 | Mapping result is valid |
| bankIdx | output | BANK_BITS | Bank number, address mod (2^BANK_BITS - 1) |
| wordIdx | output | WORD_BITS | Word offset within the bank |

## Verification
The bench builds the block with its defaults: BANK_BITS = 3, WORD_BITS = 6, ADDR_W = 9 and one register stage. At this size the full valid range of 448 addresses can be swept with one address per cycle. That sweep covers every folding path, including sums that fold twice and sums equal to the bank count, and it confirms that every address gets a distinct pair. Directed vectors at 0, 6, 7 and 447 check the edges of the range, and a cycle with valid low checks that the outputs hold.

// File: rtl/pbm_pkg.sv
package pbm_pkg;

  // Strobes from control to datapath
  typedef struct packed {
    logic capture;   // load a new mapping into the output stage
  } pbm_strobe_t;

  // Residue of bit weight 2^k modulo (2^m - 1)
  function automatic int unsigned bitResidue(input int unsigned k, input int unsigned m);
    return 32'd1 << (k % m);
  endfunction

endpackage

// File: rtl/pbm_ctrl.sv
module pbm_ctrl
  import pbm_pkg::*;
#(
  parameter int PIPE_STAGES = 1
) (
  input  logic        clk,
  input  logic        rstN,
  input  logic        inValid,
  output pbm_strobe_t strobe,
  output logic        outValid
);

  assign strobe.capture = inValid;

  generate
    if (PIPE_STAGES > 0) begin : g_reg
      logic validQ;
      always_ff @(posedge clk or negedge rstN) begin
        if (!rstN) validQ <= 1'b0;
        else       validQ <= inValid;
      end
      assign outValid = validQ;

      // R4: valid is the input valid delayed by one cycle
      a_r4_valid_latency: assert property (@(posedge clk) disable iff (!rstN)
        inValid |=> outValid);
      a_r4_valid_drop: assert property (@(posedge clk) disable iff (!rstN)
        !inValid |=> !outValid);
    end else begin : g_comb
      assign outValid = inValid;
    end
  endgenerate

endmodule

// File: rtl/pbm_fold_dp.sv
module pbm_fold_dp
  import pbm_pkg::*;
#(
  parameter int ADDR_W      = 9,
  parameter int BANK_BITS   = 3,
  parameter int WORD_BITS   = 6,
  parameter int PIPE_STAGES = 1
) (
  input  logic                 clk,
  input  logic                 rstN,
  input  pbm_strobe_t          strobe,
  input  logic [ADDR_W-1:0]    addr,
  output logic [BANK_BITS-1:0] bankIdx,
  output logic [WORD_BITS-1:0] wordIdx
);

  localparam int NB    = (1 << BANK_BITS) - 1;
  localparam int SUM_W = $clog2(ADDR_W * NB + 1) + 1;
  localparam int FOLDS = SUM_W;

  logic [SUM_W-1:0]     residueSum;
  logic [SUM_W-1:0]     folded;
  logic [BANK_BITS-1:0] bankNext;
  logic [WORD_BITS-1:0] wordNext;

  // Sum of per-bit residues, each weight fixed at build time
  always_comb begin
    residueSum = '0;
    for (int k = 0; k < ADDR_W; k++) begin
      if (addr[k]) residueSum = residueSum + SUM_W'(bitResidue(k, BANK_BITS));
    end
  end

  // End-around fold down to BANK_BITS bits
  always_comb begin
    folded = residueSum;
    for (int i = 0; i < FOLDS; i++) begin
      folded = SUM_W'(folded[BANK_BITS-1:0]) + (folded >> BANK_BITS);
    end
    bankNext = (folded[BANK_BITS-1:0] == BANK_BITS'(NB)) ? '0 : folded[BANK_BITS-1:0];
  end

  // Offset within bank: low bits
  always_comb begin
    wordNext = '0;
    for (int b = 0; b < WORD_BITS; b++) begin
      if (b < ADDR_W) wordNext[b] = addr[b];
    end
  end

  // R3: fold has settled into BANK_BITS bits
  a_r3_fold_settled: assert property (@(posedge clk) disable iff (!rstN)
    strobe.capture |-> (folded >> BANK_BITS) == '0);

  generate
    if (PIPE_STAGES > 0) begin : g_reg
      always_ff @(posedge clk or negedge rstN) begin
        if (!rstN) begin
          bankIdx <= '0;
          wordIdx <= '0;
        end else if (strobe.capture) begin
          bankIdx <= bankNext;
          wordIdx <= wordNext;
        end
      end

      // R5: outputs hold while nothing is captured
      a_r5_hold_idle: assert property (@(posedge clk) disable iff (!rstN)
        !strobe.capture |=> $stable(bankIdx) && $stable(wordIdx));
    end else begin : g_comb
      assign bankIdx = bankNext;
      assign wordIdx = wordNext;
    end
  endgenerate

endmodule

// File: rtl/prime_bank_mapper.sv
module prime_bank_mapper
  import pbm_pkg::*;
#(
  parameter int ADDR_W      = 9,
  parameter int BANK_BITS   = 3,
  parameter int WORD_BITS   = 6,
  parameter int PIPE_STAGES = 1
) (
  input  logic                 clk,
  input  logic                 rstN,
  input  logic                 inValid,
  input  logic [ADDR_W-1:0]    addr,
  output logic                 outValid,
  output logic [BANK_BITS-1:0] bankIdx,
  output logic [WORD_BITS-1:0] wordIdx
);

  localparam int NB = (1 << BANK_BITS) - 1;

  pbm_strobe_t strobe;

  pbm_ctrl #(.PIPE_STAGES(PIPE_STAGES)) uCtrl (
    .clk      (clk),
    .rstN     (rstN),
    .inValid  (inValid),
    .strobe   (strobe),
    .outValid (outValid)
  );

  pbm_fold_dp #(
    .ADDR_W      (ADDR_W),
    .BANK_BITS   (BANK_BITS),
    .WORD_BITS   (WORD_BITS),
    .PIPE_STAGES (PIPE_STAGES)
  ) uDp (
    .clk     (clk),
    .rstN    (rstN),
    .strobe  (strobe),
    .addr    (addr),
    .bankIdx (bankIdx),
    .wordIdx (wordIdx)
  );

  // R3: bank index stays below the bank count
  a_r3_bank_below_count: assert property (@(posedge clk) disable iff (!rstN)
    outValid |-> bankIdx != BANK_BITS'(NB));

  generate
    if (PIPE_STAGES > 0 && ADDR_W >= WORD_BITS) begin : g_chk
      // R2: offset is the low bits of the accepted address
      a_r2_word_low_bits: assert property (@(posedge clk) disable iff (!rstN)
        inValid |=> wordIdx == $past(addr[WORD_BITS-1:0]));
      // R1: bank index is the accepted address mod NB
      a_r1_bank_mod: assert property (@(posedge clk) disable iff (!rstN)
        inValid |=> 32'(bankIdx) == 32'($past(addr)) % NB);
    end
  endgenerate

endmodule

// File: tb/tb_prime_bank_mapper.sv
module tb_prime_bank_mapper;

  localparam int ADDR_W    = 9;
  localparam int BANK_BITS = 3;
  localparam int WORD_BITS = 6;
  localparam int NB        = (1 << BANK_BITS) - 1;
  localparam int NW        = 1 << WORD_BITS;
  localparam int SPAN      = NB * NW;

  logic                 clk = 1'b0;
  logic                 rstN = 1'b0;
  logic                 inValid = 1'b0;
  logic [ADDR_W-1:0]    addr = '0;
  logic                 outValid;
  logic [BANK_BITS-1:0] bankIdx;
  logic [WORD_BITS-1:0] wordIdx;

  int testsRun = 0;
  int testsFailed = 0;

  always #10 clk = ~clk;

  prime_bank_mapper #(
    .ADDR_W(ADDR_W), .BANK_BITS(BANK_BITS), .WORD_BITS(WORD_BITS), .PIPE_STAGES(1)
  ) dut (
    .clk(clk), .rstN(rstN), .inValid(inValid), .addr(addr),
    .outValid(outValid), .bankIdx(bankIdx), .wordIdx(wordIdx)
  );

  task automatic check(input string req, input int act, input int exp);
    testsRun++;
    if (act != exp) begin
      testsFailed++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  // Drive at negedge; result is sampled at the next negedge
  task automatic mapOne(input int a);
    @(negedge clk);
    inValid = 1'b1;
    addr    = ADDR_W'(a);
    @(negedge clk);
    check("R4 valid", int'(outValid), 1);
    check("R1 bank", int'(bankIdx), a % NB);
    check("R2 word", int'(wordIdx), a % NW);
    inValid = 1'b0;
  endtask

  task automatic testReset();
    rstN = 1'b0;
    repeat (3) @(negedge clk);
    check("R7 valid in reset", int'(outValid), 0);
    check("R7 bank in reset", int'(bankIdx), 0);
    check("R7 word in reset", int'(wordIdx), 0);
    rstN = 1'b1;
    @(negedge clk);
    check("R7 valid after reset", int'(outValid), 0);
    check("R7 bank after reset", int'(bankIdx), 0);
  endtask

  task automatic testEdges();
    mapOne(0);
    mapOne(6);
    mapOne(7);            // R3: multiple of NB gives bank 0
    check("R3 bank zero at 7", int'(bankIdx), 0);
    mapOne(14);
    check("R3 bank zero at 14", int'(bankIdx), 0);
    mapOne(SPAN - 1);     // 447 -> bank 6, word 63
    mapOne(341);          // alternating bits -> bank 5, word 21
  endtask

  task automatic testIdleHold();
    mapOne(100);          // bank 2, word 36
    @(negedge clk);
    inValid = 1'b0;
    addr    = ADDR_W'(300);
    @(negedge clk);
    check("R5 valid low", int'(outValid), 0);
    check("R5 bank held", int'(bankIdx), 2);
    check("R5 word held", int'(wordIdx), 36);
  endtask

  task automatic testSweep();
    bit seen [SPAN];
    int dupes = 0;
    int missing = 0;
    for (int i = 0; i < SPAN; i++) seen[i] = 1'b0;
    @(negedge clk);
    for (int a = 0; a < SPAN; a++) begin
      inValid = 1'b1;
      addr    = ADDR_W'(a);
      @(negedge clk);
      check("R1 sweep bank", int'(bankIdx), a % NB);
      check("R2 sweep word", int'(wordIdx), a % NW);
      check("R3 sweep below NB", int'(bankIdx < NB), 1);
      if (seen[int'(bankIdx) * NW + int'(wordIdx)]) dupes++;
      seen[int'(bankIdx) * NW + int'(wordIdx)] = 1'b1;
    end
    inValid = 1'b0;
    for (int i = 0; i < SPAN; i++) if (!seen[i]) missing++;
    check("R6 duplicate pairs", dupes, 0);
    check("R6 unused pairs", missing, 0);
  endtask

  initial begin
    #(200000 * 20);
    testsRun++;
    testsFailed++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("[TB] %0d tests run, %0d failed", testsRun, testsFailed);
    $finish;
  end

  initial begin
    testReset();
    testEdges();
    testIdleHold();
    testSweep();
    $display("[TB] %0d tests run, %0d failed", testsRun, testsFailed);
    $finish;
  end

endmodule